// File: doc/BRIEF.md
# Device-to-Memory Block Transfer Engine

This engine copies a block of bytes from a device into memory without help from the processor. Software gives it a destination address and a byte count, then sets a go bit. The engine reads the device status register and waits while its ready flag is low. When the flag is high, it reads one byte from the device data register and writes that byte to memory at the current address. The address then steps up by one and the count steps down by one. When the count reaches zero the engine goes idle and raises an interrupt. The interrupt stays high until software acknowledges it.

The device side is a plain register read port. It has a strobe and a select (0 for status, 1 for data), and the read data comes back combinationally in the same cycle. The memory side is a valid/ready stream and is the only place where back-pressure exists. The engine raises `mem_valid` with an address and a byte and holds both steady until `mem_ready` is seen high at a clock edge. `mem_ready` acts as the bus grant: a low `mem_ready` stalls the engine for as long as it lasts, and nothing is dropped. The configuration side is a register write port plus a combinational read mux. From it, software can see the busy flag, the done flag, the live address and the live remaining count.

Top module: `dmae_top`

## Requirements
- R1: After reset the engine is idle: `irq`=0, `mem_valid`=0, `dev_rd`=0, and the status, address and count reads all return 0.
- R2: The engine reads the data register (`dev_rd`=1, `dev_sel`=1) only in the cycle after a status read (`dev_sel`=0) that returned bit 0 = 1. While bit 0 reads 0 it keeps polling status and writes nothing to memory.
- R3: Each data read is followed by exactly one memory write. That write carries the byte just read (`dev_rdata[7:0]`), in read order, at the current address.
- R4: Each accepted write (`mem_valid`&&`mem_ready` at an edge) adds one to the address and subtracts one from the remaining count, both modulo their widths.
- R5: While `mem_valid`=1 and `mem_ready`=0, `mem_valid`, `mem_addr` and `mem_data` hold their values.
- R6: At the edge that accepts the last byte, busy clears and `irq` rises. `irq` then stays high until a control write (select 0) with bit 1 (acknowledge) set.
- R7: A go request (control write, bit 0) made while idle with a count of 0 raises `irq` at that edge. The engine never becomes busy and makes no device or memory access.
- R8: While busy, a go request is ignored, and writes to the address register (select 1) and the count register (select 2) are ignored.
- R9: An acknowledge written in the same cycle as the last byte's acceptance leaves `irq` set.
- R10: A go request accepted with a nonzero count clears `irq` and sets busy at that edge.
- R11: Read select 0 returns status (bit 0 busy, bit 1 done). Select 1 returns the current address. Select 2 returns the remaining count, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wsel | input | 2 | Write select: 0 control, 1 address, 2 count |
| cfg_wdata | input | ADDR_W | Write data; control bit 0 go, bit 1 acknowledge |
| cfg_rsel | input | 2 | Read select: 0 status, 1 address, 2 count |
| cfg_rdata | output | ADDR_W | Combinational read data |
| dev_rd | output | 1 | Device register read strobe |
| dev_sel | output | 1 | Device register select: 0 status, 1 data |
| dev_rdata | input | DEV_W | Device read data, same cycle; status bit 0 is ready |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory write accept / bus grant |
| mem_addr | output | ADDR_W | Byte address of the write |
| mem_data | output | 8 | Byte to write |
| irq | output | 1 | Completion interrupt, level |

## Verification
Two events can land on the same edge: the memory port accepting the final byte, which sets done, and a software acknowledge, which clears it. The bench holds `mem_ready` low until the last byte is waiting, with the live count reading 1. It then releases `mem_ready` and writes the acknowledge in the same cycle. The result passes only if `irq` is still high after that edge and the status reads idle with done set. A second acknowledge must then clear it.

// File: rtl/dmae_pkg.sv
package dmae_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_POLL  = 2'd1,
    ST_FETCH = 2'd2,
    ST_PUSH  = 2'd3
  } dmae_state_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;

  localparam int BIT_GO    = 0;
  localparam int BIT_ACK   = 1;
  localparam int BIT_READY = 0;
endpackage

// File: rtl/dmae_regs.sv
module dmae_regs
  import dmae_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_wsel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [1:0]        cfg_rsel,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              busy,
  input  logic              step,
  input  logic              fin,
  output logic              launch,
  output logic              last,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  remaining,
  output logic              irq
);
  logic go_req, ack_req, zero_go, done_q;
  logic [ADDR_W-1:0] cnt_ext;

  assign go_req  = cfg_we && (cfg_wsel == SEL_CTRL) && cfg_wdata[BIT_GO];
  assign ack_req = cfg_we && (cfg_wsel == SEL_CTRL) && cfg_wdata[BIT_ACK];
  assign launch  = go_req && !busy && (remaining != '0);
  assign zero_go = go_req && !busy && (remaining == '0);
  assign last    = (remaining == CNT_W'(1));
  assign irq     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      remaining <= '0;
      done_q    <= 1'b0;
    end else begin
      if (step) begin
        cur_addr  <= cur_addr + ADDR_W'(1);
        remaining <= remaining - CNT_W'(1);
      end else if (cfg_we && !busy) begin
        if (cfg_wsel == SEL_ADDR) cur_addr  <= cfg_wdata;
        if (cfg_wsel == SEL_CNT)  remaining <= cfg_wdata[CNT_W-1:0];
      end
      // completion and zero-length go outrank acknowledge
      if (fin || zero_go)         done_q <= 1'b1;
      else if (launch || ack_req) done_q <= 1'b0;
    end
  end

  generate
    if (CNT_W < ADDR_W) begin : g_pad
      assign cnt_ext = {{(ADDR_W-CNT_W){1'b0}}, remaining};
    end else begin : g_full
      assign cnt_ext = remaining[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    case (cfg_rsel)
      SEL_CTRL: cfg_rdata = ADDR_W'({done_q, busy});
      SEL_ADDR: cfg_rdata = cur_addr;
      SEL_CNT:  cfg_rdata = cnt_ext;
      default:  cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dmae_seq.sv
module dmae_seq
  import dmae_pkg::*;
#(
  parameter int DEV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             last,
  input  logic [DEV_W-1:0] dev_rdata,
  input  logic             mem_ready,
  output logic             dev_rd,
  output logic             dev_sel,
  output logic             mem_valid,
  output logic [7:0]       mem_data,
  output logic             step,
  output logic             fin,
  output logic             busy
);
  dmae_state_e state_q, state_d;
  logic [7:0]  byte_q;

  always_comb begin
    state_d = state_q;
    dev_rd  = 1'b0;
    dev_sel = 1'b0;
    step    = 1'b0;
    fin     = 1'b0;
    case (state_q)
      ST_IDLE:  if (launch) state_d = ST_POLL;
      ST_POLL: begin
        dev_rd = 1'b1;
        if (dev_rdata[BIT_READY]) state_d = ST_FETCH;
      end
      ST_FETCH: begin
        dev_rd  = 1'b1;
        dev_sel = 1'b1;
        state_d = ST_PUSH;
      end
      ST_PUSH: if (mem_ready) begin
        step    = 1'b1;
        fin     = last;
        state_d = last ? ST_IDLE : ST_POLL;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      byte_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_FETCH) byte_q <= dev_rdata[7:0];
    end
  end

  assign mem_valid = (state_q == ST_PUSH);
  assign mem_data  = byte_q;
  assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/dmae_top.sv
module dmae_top
  import dmae_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DEV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_wsel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [1:0]        cfg_rsel,
  output logic [ADDR_W-1:0] cfg_rdata,
  output logic              dev_rd,
  output logic              dev_sel,
  input  logic [DEV_W-1:0]  dev_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_data,
  output logic              irq
);
  logic busy, step, fin, launch, last;
  logic [CNT_W-1:0] remaining;

  dmae_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wsel(cfg_wsel),
    .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .busy(busy), .step(step), .fin(fin), .launch(launch), .last(last),
    .cur_addr(mem_addr), .remaining(remaining), .irq(irq)
  );

  dmae_seq #(.DEV_W(DEV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .last(last),
    .dev_rdata(dev_rdata), .mem_ready(mem_ready), .dev_rd(dev_rd),
    .dev_sel(dev_sel), .mem_valid(mem_valid), .mem_data(mem_data),
    .step(step), .fin(fin), .busy(busy)
  );
endmodule

// File: rtl/dmae_chk.sv
module dmae_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DEV_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [1:0]        cfg_wsel,
  input logic [ADDR_W-1:0] cfg_wdata,
  input logic              dev_rd,
  input logic              dev_sel,
  input logic [DEV_W-1:0]  dev_rdata,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_data,
  input logic              irq,
  input logic              busy,
  input logic [CNT_W-1:0]  remaining
);
  logic ctrl_wr;
  assign ctrl_wr = cfg_we && (cfg_wsel == 2'd0);

  a_r2_paced: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rd && dev_sel) |-> $past(dev_rd && !dev_sel && dev_rdata[0]));

  a_r3_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rd && dev_sel) |=> mem_valid);

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=>
      (mem_addr == $past(mem_addr) + ADDR_W'(1)) &&
      (remaining == $past(remaining) - CNT_W'(1)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      mem_valid && $stable(mem_addr) && $stable(mem_data));

  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(ctrl_wr && (cfg_wdata[0] || cfg_wdata[1]))) |=> irq);

  a_r7_zero_go: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && cfg_wdata[0] && !busy && remaining == '0) |=> (irq && !busy));

  a_r8_busy_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we && cfg_wsel == 2'd2 && !(mem_valid && mem_ready))
      |=> $stable(remaining));

  a_r9_finish_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && remaining == CNT_W'(1)) |=> (irq && !busy));
endmodule

bind dmae_top dmae_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEV_W(DEV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wsel(cfg_wsel),
  .cfg_wdata(cfg_wdata), .dev_rd(dev_rd), .dev_sel(dev_sel),
  .dev_rdata(dev_rdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq), .busy(busy),
  .remaining(remaining)
);

// File: tb/sim_dmae_top.sv
`timescale 1ns/1ps
module sim_dmae_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_wsel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0] cfg_rsel = 2'd0;
  logic [31:0] cfg_rdata;
  logic dev_rd, dev_sel, mem_valid, mem_ready, irq;
  logic [7:0] dev_rdata, mem_data;
  logic [31:0] mem_addr;

  always #4 clk = ~clk;

  dmae_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wsel(cfg_wsel),
    .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .dev_rd(dev_rd), .dev_sel(dev_sel), .dev_rdata(dev_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .irq(irq)
  );

  // device model: ready drops for gap_cfg cycles after each data read
  logic [3:0] gap_cfg = 4'd0, gap_cnt = 4'd0;
  logic [7:0] seed = 8'd0;
  int dev_idx = 0, wr_n = 0, mon_err = 0, r2_err = 0;
  logic clr = 1'b0;
  logic [31:0] exp_base = '0;
  logic dev_ready;

  function automatic logic [7:0] dbyte(int i, logic [7:0] s);
    return 8'(i * 37) + s;
  endfunction

  assign dev_ready = (gap_cnt == 4'd0);
  assign dev_rdata = dev_sel ? dbyte(dev_idx, seed) : {7'b0, dev_ready};

  always @(posedge clk) begin
    if (clr) begin
      dev_idx <= 0; gap_cnt <= gap_cfg; wr_n <= 0; mon_err <= 0; r2_err <= 0;
    end else begin
      if (dev_rd && dev_sel) begin
        if (!dev_ready) r2_err <= r2_err + 1;
        dev_idx <= dev_idx + 1;
        gap_cnt <= gap_cfg;
      end else if (gap_cnt != 4'd0) gap_cnt <= gap_cnt - 4'd1;
      if (mem_valid && mem_ready) begin
        if (mem_addr !== exp_base + 32'(wr_n) || mem_data !== dbyte(wr_n, seed))
          mon_err <= mon_err + 1;
        wr_n <= wr_n + 1;
      end
      if ((mem_valid || (dev_rd && dev_sel)) && !dev_ready && !mem_valid && dev_sel)
        r2_err <= r2_err + 1;
    end
  end

  // memory ready: stall pattern or manual override
  logic [7:0] stall_pat = 8'h00;
  logic [2:0] stall_ph = 3'd0;
  logic ovr_en = 1'b0, ovr = 1'b0;
  always @(negedge clk) stall_ph <= stall_ph + 3'd1;
  assign mem_ready = ovr_en ? ovr : ~stall_pat[stall_ph];

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wsel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] val);
    cfg_rsel = sel; #1; val = cfg_rdata;
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 4000; k++) begin
      if (irq) break;
      @(negedge clk);
    end
  endtask

  task automatic start_run(input logic [31:0] base, input logic [3:0] gap,
                           input logic [7:0] s, input logic [7:0] pat);
    @(negedge clk);
    gap_cfg = gap; seed = s; stall_pat = pat; exp_base = base; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] len;
    logic [3:0]  gap;
    logic [7:0]  stall;
    logic [7:0]  seed;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'h0000_1000, 16'd1,  4'd0, 8'h00, 8'h11},
    '{32'h2000_00F0, 16'd5,  4'd3, 8'h00, 8'h42},
    '{32'h0000_3000, 16'd12, 4'd0, 8'hA6, 8'h07},
    '{32'hFFFF_FFFE, 16'd4,  4'd1, 8'h0F, 8'hC3},
    '{32'h0000_0100, 16'd40, 4'd2, 8'h63, 8'h5A}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!irq && !mem_valid && !dev_rd, "R1 idle outputs", {irq, mem_valid, dev_rd}, 0);
    rd(2'd0, v); chk(v == 0, "R1 status", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 address", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 count", v, 0);

    // table-driven transfers
    foreach (VECS[i]) begin
      start_run(VECS[i].base, VECS[i].gap, VECS[i].seed, VECS[i].stall);
      cfg_write(2'd1, VECS[i].base);
      cfg_write(2'd2, 32'(VECS[i].len));
      cfg_write(2'd0, 32'h1);
      rd(2'd0, v);
      chk(v == 32'h1 && !irq, "R10 go clears done, sets busy", v, 1);
      wait_irq();
      @(negedge clk);
      chk(wr_n == int'(VECS[i].len), "R3 one write per byte", wr_n, VECS[i].len);
      chk(mon_err == 0, "R3/R4 byte and address order", mon_err, 0);
      chk(r2_err == 0, "R2 data read only when ready", r2_err, 0);
      rd(2'd1, v);
      chk(v == VECS[i].base + 32'(VECS[i].len), "R4 final address", v, VECS[i].base + 32'(VECS[i].len));
      rd(2'd2, v); chk(v == 0, "R11 count reads zero", v, 0);
      rd(2'd0, v); chk(v == 32'h2, "R6 idle with done", v, 2);
    end

    // R6: interrupt holds until acknowledged
    repeat (6) @(negedge clk);
    chk(irq, "R6 irq held", irq, 1);
    cfg_write(2'd0, 32'h2);
    chk(!irq, "R6 irq cleared by ack", irq, 0);

    // R7: zero length
    start_run(32'h0000_0800, 4'd0, 8'h00, 8'h00);
    cfg_write(2'd2, 32'h0);
    cfg_write(2'd0, 32'h1);
    rd(2'd0, v);
    chk(irq && v == 32'h2, "R7 zero count completes, never busy", v, 2);
    repeat (4) @(negedge clk);
    chk(wr_n == 0 && dev_idx == 0 && !dev_rd, "R7 no accesses", wr_n, 0);
    cfg_write(2'd0, 32'h2);

    // R8: go, address and count writes ignored while busy
    start_run(32'h0000_4000, 4'd15, 8'h33, 8'h00);
    cfg_write(2'd1, 32'h0000_4000);
    cfg_write(2'd2, 32'd3);
    cfg_write(2'd0, 32'h1);
    cfg_write(2'd1, 32'h0000_9999);
    cfg_write(2'd2, 32'd77);
    cfg_write(2'd0, 32'h1);
    rd(2'd1, v); chk(v == 32'h0000_4000, "R8 address write ignored", v, 32'h4000);
    rd(2'd2, v); chk(v == 32'd3, "R8 count write ignored", v, 3);
    // R2: while gap holds ready low no data read or write occurs
    chk(dev_idx == 0 && wr_n == 0, "R2 waits on ready", dev_idx, 0);
    wait_irq();
    repeat (60) @(negedge clk);
    chk(wr_n == 3 && mon_err == 0, "R8 single run of original length", wr_n, 3);
    rd(2'd0, v); chk(v == 32'h2, "R8 no second run", v, 2);

    // R5 and R9: hold last byte, release together with ack
    start_run(32'h0000_0500, 4'd0, 8'h90, 8'h00);
    ovr_en = 1'b1; ovr = 1'b1;
    cfg_write(2'd1, 32'h0000_0500);
    cfg_write(2'd2, 32'd2);
    cfg_write(2'd0, 32'h1);
    for (int k = 0; k < 100; k++) begin
      rd(2'd2, v);
      if (v == 1) break;
      @(negedge clk);
    end
    ovr = 1'b0;
    for (int k = 0; k < 100; k++) begin
      if (mem_valid) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(mem_valid && mem_addr == 32'h501 && mem_data == dbyte(1, 8'h90),
        "R5 stalled write held", mem_addr, 32'h501);
    cfg_we = 1'b1; cfg_wsel = 2'd0; cfg_wdata = 32'h2; ovr = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; ovr_en = 1'b0;
    rd(2'd0, v);
    chk(irq && v == 32'h2, "R9 completion beats ack", v, 2);
    chk(wr_n == 2 && mon_err == 0, "R9 both bytes written", wr_n, 2);
    cfg_write(2'd0, 32'h2);
    chk(!irq, "R9 later ack clears", irq, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule